// File: doc/BRIEF.md
# Transmit Backoff and Timeout Controller

This block decides when a transmitter retries after a collision and when it gives up on a transmission that has run too long. A free-running random counter advances on every clock. Each time its low `TICK_W` bits carry out, the block sees one tick. Ticks are the only time base for both the retry delay and the watchdog.

A start pulse begins a transmission and clears all backoff state. Each collision abort widens a backoff mask by shifting a one into its low end. The retry delay is then the random counter ANDed with that mask. A zero delay restarts the transmission on the next cycle. A non-zero delay is counted down on ticks, and the restart strobe fires when the count reaches zero. A separate timer is also counted down on ticks for as long as the transmission stays active. It starts from zero, so its first decrement wraps and the timeout covers the full range of the timer. When the timer reaches zero, the block drops the transmission and raises a sticky timeout flag.

Top module: `txbo_ctrl`

## Requirements
- R1: After reset, `active_o`, `timeout_o`, `restart_o`, `abort_ack_o` and `waiting_o` are all 0, and the random counter holds 0.
- R2: A cycle with `start_i` high sets `active_o` to 1 and clears `timeout_o`, the mask, the retry delay and the timer, all visible from the next cycle.
- R3: The random counter adds one on every clock. A tick occurs on a cycle in which the low `TICK_W` bits of the counter are all ones.
- R4: An abort taken while active pulses `abort_ack_o` for one cycle, starting the next cycle. It also widens the mask to `(mask << 1) | 1`, limited to its low `MASK_LIMIT` bits, so the mask stops growing once those bits are all ones.
- R5: On an accepted abort, the delay is the current random counter value ANDed with the widened mask. A delay of zero makes `restart_o` pulse for one cycle on the next cycle.
- R6: A non-zero delay holds `waiting_o` high and drops by one on each active tick. The tick that brings it to zero makes `restart_o` pulse on the next cycle.
- R7: Each active tick decrements the timer, which starts at 0 and wraps. When the result is zero, `active_o` falls, `timeout_o` rises and any pending delay is discarded with no restart. This takes `2^TMR_W` ticks after a start.
- R8: `timeout_o` stays high until the next `start_i`.
- R9: While inactive, ticks change nothing, and an abort is ignored: there is no acknowledge, no restart, and the mask does not change.
- R10: `start_i` overrides an abort and a tick in the same cycle. An abort arriving on an active tick still lets that tick decrement the timer, but the new delay replaces the old countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | A new transmission begins |
| abort_i | input | 1 | The current attempt hit a collision |
| restart_o | output | 1 | One-cycle pulse: restart the transmission now |
| abort_ack_o | output | 1 | One-cycle acknowledge of an accepted abort |
| timeout_o | output | 1 | Sticky: the transmission ran out of time |
| active_o | output | 1 | A transmission is in progress |
| waiting_o | output | 1 | A non-zero backoff delay is counting down |

## Verification
Two cases are hard to reach from the ports: an abort that lands exactly on a tick cycle, and a mask that has grown all the way to its cap. Both need a specific alignment between the stimulus and the hidden random counter. The bench keeps its own copy of that counter from reset, so it can wait for the cycle before a carry and issue the abort there. It then sends a burst of back-to-back aborts to drive the mask to saturation. Random phases mix starts and aborts across long active stretches, which lets full timeouts and countdown restarts occur at many counter phases.

// File: rtl/txbo_pkg.sv
package txbo_pkg;
   // Restart cause, used only for readability in the controller
   typedef enum logic [1:0] {
      RS_NONE      = 2'd0,
      RS_IMMEDIATE = 2'd1,
      RS_COUNTED   = 2'd2
   } restart_cause_e;

   // Pending backoff bookkeeping chosen each cycle
   typedef enum logic [1:0] {
      RT_HOLD  = 2'd0,
      RT_CLEAR = 2'd1,
      RT_LOAD  = 2'd2,
      RT_DEC   = 2'd3
   } retry_op_e;
endpackage

// File: rtl/txbo_rand_tick.sv
// Free-running random counter; tick when the low bits carry out (R3)
module txbo_rand_tick #(
   parameter int RND_W  = 16,
   parameter int TICK_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [RND_W-1:0] rnd_o,
   output logic             tick_o
);
   localparam logic [RND_W-1:0] ONE = RND_W'(1);

   logic [RND_W-1:0] rnd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rnd_q <= '0;
      else        rnd_q <= rnd_q + ONE;
   end

   assign rnd_o  = rnd_q;
   assign tick_o = &rnd_q[TICK_W-1:0];
endmodule

// File: rtl/txbo_mask.sv
// Backoff mask: clears on start, widens by one bit per abort, capped at LIMIT bits
module txbo_mask #(
   parameter int MASK_W     = 16,
   parameter int MASK_LIMIT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              widen_i,
   output logic [MASK_W-1:0] mask_o,
   output logic [MASK_W-1:0] mask_next_o
);
   logic [MASK_W-1:0] mask_q;
   logic [MASK_W-1:0] widened;

   for (genvar i = 0; i < MASK_W; i++) begin : g_bit
      if (i >= MASK_LIMIT) begin : g_capped
         assign widened[i] = 1'b0;
      end else if (i == 0) begin : g_low
         assign widened[i] = 1'b1;
      end else begin : g_shift
         assign widened[i] = mask_q[i-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (clr_i)   mask_q <= '0;
      else if (widen_i) mask_q <= widened;
   end

   assign mask_o      = mask_q;
   assign mask_next_o = widened;
endmodule

// File: rtl/txbo_downcnt.sv
// Generic wrapping down counter with clear, load and decrement
module txbo_downcnt #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic [W-1:0] cnt_o,
   output logic         at_one_o,
   output logic         is_zero_o
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (dec_i)  cnt_q <= cnt_q - ONE;
   end

   assign cnt_o     = cnt_q;
   assign at_one_o  = (cnt_q == ONE);
   assign is_zero_o = (cnt_q == '0);
endmodule

// File: rtl/txbo_ctrl.sv
module txbo_ctrl
   import txbo_pkg::*;
#(
   parameter int RND_W      = 16,
   parameter int TICK_W     = 8,
   parameter int MASK_W     = 16,
   parameter int MASK_LIMIT = 16,
   parameter int TMR_W      = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic abort_i,
   output logic restart_o,
   output logic abort_ack_o,
   output logic timeout_o,
   output logic active_o,
   output logic waiting_o
);
   localparam int DLY_W = MASK_W;

   if (TICK_W < 1 || TICK_W >= RND_W) begin : g_bad_tick
      $error("txbo_ctrl: TICK_W must be in 1..RND_W-1");
   end
   if (MASK_W < 1 || MASK_W > RND_W) begin : g_bad_mask
      $error("txbo_ctrl: MASK_W must be in 1..RND_W");
   end
   if (MASK_LIMIT < 1 || MASK_LIMIT > MASK_W) begin : g_bad_limit
      $error("txbo_ctrl: MASK_LIMIT must be in 1..MASK_W");
   end
   if (TMR_W < 2) begin : g_bad_tmr
      $error("txbo_ctrl: TMR_W must be at least 2");
   end

   logic [RND_W-1:0]  rnd;
   logic              tick;
   logic [MASK_W-1:0] mask_cur, mask_nxt;
   logic [DLY_W-1:0]  delay, retry_cnt;
   logic [TMR_W-1:0]  tmr_cnt;
   logic              retry_one, retry_zero, tmr_one, tmr_zero;
   logic              act_q, to_q, restart_q, ack_q;
   logic              act_tick, abort_ok, expire;
   retry_op_e         rop;
   restart_cause_e    cause;

   txbo_rand_tick #(.RND_W(RND_W), .TICK_W(TICK_W)) u_rnd (
      .clk(clk), .rst_n(rst_n), .rnd_o(rnd), .tick_o(tick)
   );

   // Qualified events; start has top priority (R10)
   assign act_tick = tick & act_q & ~start_i;
   assign abort_ok = abort_i & act_q & ~start_i;
   assign expire   = act_tick & tmr_one;

   txbo_mask #(.MASK_W(MASK_W), .MASK_LIMIT(MASK_LIMIT)) u_mask (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .widen_i(abort_ok),
      .mask_o(mask_cur), .mask_next_o(mask_nxt)
   );

   assign delay = rnd[DLY_W-1:0] & mask_nxt;

   // Watchdog timer: starts at zero so first decrement wraps (R7)
   txbo_downcnt #(.W(TMR_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clr_i(start_i), .load_i(1'b0),
      .load_val_i('0), .dec_i(act_tick),
      .cnt_o(tmr_cnt), .at_one_o(tmr_one), .is_zero_o(tmr_zero)
   );

   always_comb begin
      if (start_i || expire)               rop = RT_CLEAR;
      else if (abort_ok)                   rop = RT_LOAD;
      else if (act_tick && !retry_zero)    rop = RT_DEC;
      else                                 rop = RT_HOLD;
   end

   txbo_downcnt #(.W(DLY_W)) u_retry (
      .clk(clk), .rst_n(rst_n), .clr_i(rop == RT_CLEAR),
      .load_i(rop == RT_LOAD), .load_val_i(delay), .dec_i(rop == RT_DEC),
      .cnt_o(retry_cnt), .at_one_o(retry_one), .is_zero_o(retry_zero)
   );

   always_comb begin
      cause = RS_NONE;
      if (rop == RT_LOAD && delay == '0)  cause = RS_IMMEDIATE;
      else if (rop == RT_DEC && retry_one) cause = RS_COUNTED;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q     <= 1'b0;
         to_q      <= 1'b0;
         restart_q <= 1'b0;
         ack_q     <= 1'b0;
      end else begin
         restart_q <= (cause != RS_NONE);
         ack_q     <= abort_ok;
         if (start_i) begin
            act_q <= 1'b1;
            to_q  <= 1'b0;
         end else if (expire) begin
            act_q <= 1'b0;
            to_q  <= 1'b1;
         end
      end
   end

   assign restart_o   = restart_q;
   assign abort_ack_o = ack_q;
   assign timeout_o   = to_q;
   assign active_o    = act_q;
   assign waiting_o   = ~retry_zero;
endmodule

// File: rtl/txbo_ctrl_chk.sv
module txbo_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic abort_i,
   input logic restart_o,
   input logic abort_ack_o,
   input logic timeout_o,
   input logic active_o,
   input logic waiting_o
);
   AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> (active_o && !timeout_o && !waiting_o)); // R2
   AST_ACK_ON_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      (abort_i && active_o && !start_i) |=> abort_ack_o); // R4
   AST_RESTART_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      restart_o |-> active_o); // R5
   AST_WAIT_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      waiting_o |-> active_o); // R6
   AST_TIMEOUT_DROPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      timeout_o |-> !active_o); // R7
   AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_o && !start_i) |=> timeout_o); // R8
   AST_INACTIVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_o && !start_i) |=> (!active_o && !restart_o && !abort_ack_o)); // R9
   AST_START_BEATS_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !abort_ack_o && !restart_o); // R10
endmodule

bind txbo_ctrl txbo_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
   .restart_o(restart_o), .abort_ack_o(abort_ack_o), .timeout_o(timeout_o),
   .active_o(active_o), .waiting_o(waiting_o)
);

// File: tb/txbo_ctrl_bench.sv
`timescale 1ns/1ps
module txbo_ctrl_bench;
   localparam int RW = 8, TW = 4, MW = 6, ML = 5, TMW = 4;

   logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, abort_i = 1'b0;
   logic restart_o, abort_ack_o, timeout_o, active_o, waiting_o;
   int   n_tests = 0, n_fail = 0;

   always #10 clk = ~clk;

   txbo_ctrl #(.RND_W(RW), .TICK_W(TW), .MASK_W(MW), .MASK_LIMIT(ML), .TMR_W(TMW))
   u_txbo_ctrl (.clk(clk), .rst_n(rst_n), .start_i(start_i), .abort_i(abort_i),
      .restart_o(restart_o), .abort_ack_o(abort_ack_o), .timeout_o(timeout_o),
      .active_o(active_o), .waiting_o(waiting_o));

   // Reference state built from the requirements
   logic [RW-1:0]  m_rnd;
   logic [MW-1:0]  m_mask, m_retry;
   logic [TMW-1:0] m_tmr;
   logic m_act, m_to, m_rs, m_ack;

   function automatic logic [MW-1:0] widen(input logic [MW-1:0] m);
      return ((m << 1) | MW'(1)) & MW'((1 << ML) - 1);   // R4 cap at ML bits
   endfunction

   function automatic logic is_tick(input logic [RW-1:0] r);
      return r[TW-1:0] == {TW{1'b1}};                    // R3
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_rnd = '0; m_mask = '0; m_retry = '0; m_tmr = '0;
         m_act = 0; m_to = 0; m_rs = 0; m_ack = 0;
      end else begin
         logic at, aok, exp_t;
         logic [MW-1:0] nm, dly;
         at    = is_tick(m_rnd) && m_act && !start_i;
         aok   = abort_i && m_act && !start_i;
         exp_t = at && (m_tmr == TMW'(1));
         nm    = widen(m_mask);
         dly   = m_rnd[MW-1:0] & nm;
         m_rs  = 0;
         m_ack = aok;
         if (start_i) begin
            m_act = 1; m_to = 0; m_mask = '0; m_retry = '0; m_tmr = '0;
         end else begin
            if (aok) m_mask = nm;
            if (at) m_tmr = m_tmr - 1'b1;
            if (exp_t) begin
               m_act = 0; m_to = 1; m_retry = '0;
            end else if (aok) begin
               m_retry = dly;
               m_rs = (dly == '0);
            end else if (at && m_retry != '0) begin
               m_retry = m_retry - 1'b1;
               m_rs = (m_retry == '0);
            end
         end
         m_rnd = m_rnd + 1'b1;
      end
   end

   task automatic chk(input string req, input logic got, input logic expv);
      n_tests++;
      if (got !== expv) begin
         n_fail++;
         $display("FAIL %s at %0t: got %0b expected %0b", req, $time, got, expv);
      end
   endtask

   task automatic check_all();
      chk("R5 R6 restart_o", restart_o, m_rs);
      chk("R4 R9 R10 abort_ack_o", abort_ack_o, m_ack);
      chk("R2 R7 active_o", active_o, m_act);
      chk("R7 R8 timeout_o", timeout_o, m_to);
      chk("R6 waiting_o", waiting_o, m_retry != '0);
   endtask

   // Apply one cycle of stimulus, then compare after the edge
   task automatic step(input logic s, input logic a);
      start_i = s; abort_i = a;
      @(negedge clk);
      check_all();
   endtask

   initial begin
      #(20 * 20000);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd7311));
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 active", active_o, 1'b0);
      chk("R1 timeout", timeout_o, 1'b0);
      chk("R1 restart", restart_o, 1'b0);
      chk("R1 ack", abort_ack_o, 1'b0);
      chk("R1 waiting", waiting_o, 1'b0);
      rst_n = 1'b1;
      // R9: aborts while inactive are ignored
      for (int i = 0; i < 40; i++) step(1'b0, i[0]);
      // R2 R7 R8: start, then run to full timeout and stay there
      step(1'b1, 1'b0);
      for (int i = 0; i < 300; i++) step(1'b0, 1'b0);
      chk("R8 timeout held", timeout_o, 1'b1);
      chk("R7 inactive after timeout", active_o, 1'b0);
      // R2 clears timeout
      step(1'b1, 1'b0);
      chk("R2 timeout cleared", timeout_o, 1'b0);
      // R10: abort exactly on a tick cycle
      while (!is_tick(m_rnd)) step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
      // R4: burst of aborts drives the mask to its cap
      for (int i = 0; i < 9; i++) step(1'b0, 1'b1);
      for (int i = 0; i < 200; i++) step(1'b0, 1'b0);
      // R10: start and abort together
      step(1'b1, 1'b1);
      chk("R10 no ack with start", abort_ack_o, 1'b0);
      // Random phase: R3 R5 R6 across many counter phases
      for (int i = 0; i < 6000; i++)
         step(($urandom % 180) == 0, ($urandom % 14) == 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule